// File: doc/BRIEF.md
# Prescaled Scanline Interrupt Counter

This block raises a CPU interrupt after a programmable number of video scanlines for a cartridge memory mapper. It watches one bit of the video address bus, bit 12. Each 1-to-0 transition of that bit counts as one pulse. The pulses pass through a divide-by-eight prescaler. Only the first pulse of each group of eight clocks a reloadable 8-bit down-counter. When a counter clock leaves the count at zero while interrupts are enabled, the active-high interrupt line asserts on that same clock edge. It then stays asserted until software acknowledges it.

Software programs the block through a plain write port. The port has an address, a data byte and a write strobe. Writes are accepted on every strobed cycle and have no back-pressure, so the port carries no ready signal. Only address bits 15:13 and bit 0 take part in decoding; all other address bits are ignored. Of the four decoded registers, one holds the reload value and one requests a reload. The remaining two switch interrupts off and on.

Top module: `line_irq_divcounter`

## Requirements
- R1: After reset `irq` is low, the reload value and count are 0, interrupts are disabled, no reload is pending and the prescaler is at phase 0.
- R2: A pulse is counted only in a cycle where the registered previous value of `vid_line_bit` is 1 and the current value is 0. Rising edges are ignored, and so are cycles where the bit holds.
- R3: The prescaler advances on every pulse and wraps after 8 pulses. The down-counter is clocked only by the pulse that moves the prescaler out of phase 0, which is the first pulse of each group of 8.
- R4: A write whose address ANDed with 0xE001 equals 0xC001 returns the prescaler to phase 0 and sets the reload flag. A pulse in the same cycle as such a write is discarded and does not clock the counter.
- R5: On a counter clock, the count loads the reload value if it is 0 or the reload flag is set. Otherwise it decrements by 1. The reload flag is cleared on every counter clock.
- R6: If a counter clock leaves the count at 0 while interrupts are enabled, `irq` rises right after that clock edge. Consequently, after a reload request with reload value N, the first `irq` follows pulse 8*N+1.
- R7: A write decoding to 0xC000 stores `cpu_wdata` as the reload value. The stored value takes effect at the next reload and does not alter the current count.
- R8: A write decoding to 0xE000 disables interrupts and drops `irq`. A write decoding to 0xE001 enables interrupts. Once set, `irq` stays high until a 0xE000 write.
- R9: While interrupts are disabled, a counter clock that reaches 0 does not raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_line_bit | input | 1 | Bit 12 of the video address bus, sampled in the system clock domain |
| cpu_wr_en | input | 1 | Write strobe, one write per strobed cycle |
| cpu_addr | input | 16 | Write address; bits 15:13 and bit 0 are decoded |
| cpu_wdata | input | 8 | Write data |
| irq | output | 1 | Active-high interrupt request |

## Verification
The checker watches every cycle for several properties. It confirms that `irq` is low after reset and that it drops on an acknowledge. It also confirms that `irq` holds until that acknowledge. Finally, it confirms that `irq` can only rise on a pulse that lands on prescaler phase 0 while interrupts are enabled. The bench's scenarios are needed to show the exact count arithmetic: the first interrupt at pulse 8*N+1 for a sweep of reload values, reload on zero versus decrement, a new reload value taking effect only at the next reload, and realignment of the prescaler by a reload request issued mid-group or in the same cycle as a pulse.

// File: rtl/lirq_pkg.sv
package lirq_pkg;

  localparam int unsigned CPU_AW = 16;
  localparam logic [CPU_AW-1:0] DEC_MASK = 16'hE001;

  localparam logic [CPU_AW-1:0] SEL_RELOAD_VAL = 16'hC000;
  localparam logic [CPU_AW-1:0] SEL_RELOAD_REQ = 16'hC001;
  localparam logic [CPU_AW-1:0] SEL_IRQ_OFF    = 16'hE000;
  localparam logic [CPU_AW-1:0] SEL_IRQ_ON     = 16'hE001;

  typedef enum logic [2:0] {
    WR_NONE,
    WR_RELOAD_VAL,
    WR_RELOAD_REQ,
    WR_IRQ_OFF,
    WR_IRQ_ON
  } lirq_wr_e;

  function automatic lirq_wr_e lirq_decode(input logic en, input logic [CPU_AW-1:0] a);
    lirq_wr_e k;
    k = WR_NONE;
    if (en) begin
      unique case (a & DEC_MASK)
        SEL_RELOAD_VAL: k = WR_RELOAD_VAL;
        SEL_RELOAD_REQ: k = WR_RELOAD_REQ;
        SEL_IRQ_OFF:    k = WR_IRQ_OFF;
        SEL_IRQ_ON:     k = WR_IRQ_ON;
        default:        k = WR_NONE;
      endcase
    end
    return k;
  endfunction

endpackage

// File: rtl/lirq_regdec.sv
module lirq_regdec #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [lirq_pkg::CPU_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [DATA_W-1:0]         reload_val,
  output logic                      reload_req,
  output logic                      irq_off,
  output logic                      irq_on
);
  import lirq_pkg::*;

  lirq_wr_e kind;

  always_comb begin
    kind       = lirq_decode(wr_en, wr_addr);
    reload_req = (kind == WR_RELOAD_REQ);
    irq_off    = (kind == WR_IRQ_OFF);
    irq_on     = (kind == WR_IRQ_ON);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_val <= '0;
    end else if (kind == WR_RELOAD_VAL) begin
      reload_val <= wr_data;
    end
  end

endmodule

// File: rtl/lirq_edge_div.sv
module lirq_edge_div #(
  parameter int unsigned DIVIDE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_bit,
  input  logic realign,
  output logic tick
);
  localparam int unsigned PH_W = (DIVIDE > 1) ? $clog2(DIVIDE) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIVIDE - 1);

  logic line_prev;
  logic pulse;

  always_ff @(posedge clk) begin
    if (!rst_n) line_prev <= 1'b0;
    else        line_prev <= line_bit;
  end

  assign pulse = line_prev & ~line_bit & ~realign;

  generate
    if (DIVIDE > 1) begin : g_div
      logic [PH_W-1:0] phase;

      always_ff @(posedge clk) begin
        if (!rst_n || realign) begin
          phase <= '0;
        end else if (pulse) begin
          phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
        end
      end

      assign tick = pulse && (phase == '0);
    end else begin : g_nodiv
      assign tick = pulse;
    end
  endgenerate

endmodule

// File: rtl/lirq_downcnt.sv
module lirq_downcnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             reload_req,
  input  logic             irq_off,
  input  logic             irq_on,
  output logic             irq
);
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] count_nx;
  logic             reload_flag;
  logic             enabled;
  logic             fire;

  always_comb begin
    if (count == '0 || reload_flag) count_nx = reload_val;
    else                            count_nx = count - 1'b1;
    fire = tick && (count_nx == '0) && enabled && !irq_off;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count       <= '0;
      reload_flag <= 1'b0;
      enabled     <= 1'b0;
      irq         <= 1'b0;
    end else begin
      if (tick) begin
        count       <= count_nx;
        reload_flag <= 1'b0;
      end
      if (reload_req) reload_flag <= 1'b1;

      if (irq_off)     enabled <= 1'b0;
      else if (irq_on) enabled <= 1'b1;

      if (irq_off)   irq <= 1'b0;
      else if (fire) irq <= 1'b1;
    end
  end

endmodule

// File: rtl/line_irq_divcounter.sv
module line_irq_divcounter #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned PRESCALE = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        vid_line_bit,
  input  logic                        cpu_wr_en,
  input  logic [lirq_pkg::CPU_AW-1:0] cpu_addr,
  input  logic [DATA_W-1:0]           cpu_wdata,
  output logic                        irq
);
  logic [DATA_W-1:0] reload_val;
  logic              reload_req;
  logic              irq_off;
  logic              irq_on;
  logic              tick;

  lirq_regdec #(.DATA_W(DATA_W)) u_regdec (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cpu_wr_en),
    .wr_addr    (cpu_addr),
    .wr_data    (cpu_wdata),
    .reload_val (reload_val),
    .reload_req (reload_req),
    .irq_off    (irq_off),
    .irq_on     (irq_on)
  );

  lirq_edge_div #(.DIVIDE(PRESCALE)) u_edge_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_bit (vid_line_bit),
    .realign  (reload_req),
    .tick     (tick)
  );

  lirq_downcnt #(.CNT_W(DATA_W)) u_downcnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .reload_val (reload_val),
    .reload_req (reload_req),
    .irq_off    (irq_off),
    .irq_on     (irq_on),
    .irq        (irq)
  );

endmodule

// File: rtl/lirq_checker.sv
module lirq_checker #(
  parameter int unsigned PRESCALE = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        vid_line_bit,
  input logic                        cpu_wr_en,
  input logic [lirq_pkg::CPU_AW-1:0] cpu_addr,
  input logic                        irq
);
  import lirq_pkg::*;

  localparam int unsigned PH_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  lirq_wr_e        k;
  logic            seen_prev;
  logic            fall;
  logic            en_shadow;
  logic [PH_W-1:0] ph_shadow;

  assign k    = lirq_decode(cpu_wr_en, cpu_addr);
  assign fall = seen_prev && !vid_line_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_prev <= 1'b0;
      en_shadow <= 1'b0;
      ph_shadow <= '0;
    end else begin
      seen_prev <= vid_line_bit;
      if (k == WR_IRQ_OFF)     en_shadow <= 1'b0;
      else if (k == WR_IRQ_ON) en_shadow <= 1'b1;
      if (k == WR_RELOAD_REQ)  ph_shadow <= '0;
      else if (fall)           ph_shadow <= (int'(ph_shadow) == PRESCALE - 1) ? '0 : ph_shadow + 1'b1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !irq); // R1

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (k == WR_IRQ_OFF) |=> !irq); // R8

  AST_HELD_TILL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && k != WR_IRQ_OFF) |=> irq); // R8

  AST_RISE_NEEDS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !fall) |=> !irq); // R2

  AST_RISE_ON_PHASE0: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && ((fall && ph_shadow != '0) || k == WR_RELOAD_REQ)) |=> !irq); // R3

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !en_shadow) |=> !irq); // R9

endmodule

bind line_irq_divcounter lirq_checker #(.PRESCALE(PRESCALE)) i_lirq_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .vid_line_bit (vid_line_bit),
  .cpu_wr_en    (cpu_wr_en),
  .cpu_addr     (cpu_addr),
  .irq          (irq)
);

// File: tb/test_line_irq_divcounter.sv
module test_line_irq_divcounter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vid_line_bit = 1'b0;
  logic        cpu_wr_en = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  line_irq_divcounter i_line_irq_divcounter (
    .clk(clk), .rst_n(rst_n), .vid_line_bit(vid_line_bit),
    .cpu_wr_en(cpu_wr_en), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .irq(irq)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: irq=%0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    cpu_wr_en = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(posedge clk); #1;
    cpu_wr_en = 1'b0;
  endtask

  // one full pulse on the line bit: high for two cycles, then low
  task automatic pulse_line();
    vid_line_bit = 1'b1; @(posedge clk); #1;
    @(posedge clk); #1;
    vid_line_bit = 1'b0; @(posedge clk); #1;
  endtask

  task automatic arm(input logic [7:0] n);
    wr(16'hE000, 8'h00);
    wr(16'hC000, n);
    wr(16'hC001, 8'h00);
    wr(16'hE001, 8'h00);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: irq=%0b expected run to end", irq);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(irq, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(irq, 1'b0, "R1 after reset");

    // R6 R3 R2: sweep reload values, mirrored addresses, first irq at pulse 8N+1
    for (int n = 0; n < 8; n++) begin
      wr(16'hE000 | 16'(n << 5), 8'h00);
      wr(16'hC000 | 16'(n << 8), 8'(n));
      wr(16'hC001 | 16'(n << 4), 8'h00);
      wr(16'hE001 | 16'(n << 2), 8'h00);
      for (int e = 1; e <= 8*n + 3; e++) begin
        pulse_line();
        chk(irq, (e >= 8*n + 1), $sformatf("R6 R3 R2 n=%0d pulse=%0d", n, e));
      end
    end

    // R9 R8: disabled counter reaching zero stays quiet; enable lets it fire
    arm(8'd0);
    wr(16'hE000, 8'h00);
    pulse_line();
    chk(irq, 1'b0, "R9 disabled zero");
    for (int e = 0; e < 7; e++) pulse_line();
    chk(irq, 1'b0, "R9 disabled group");
    wr(16'hE001, 8'h00);
    pulse_line();
    chk(irq, 1'b1, "R8 enable then fire");
    for (int e = 0; e < 9; e++) pulse_line();
    chk(irq, 1'b1, "R8 held until ack");
    wr(16'hE000, 8'h00);
    chk(irq, 1'b0, "R8 ack drops");

    // R4: reload request mid-group realigns the prescaler
    arm(8'd1);
    pulse_line();
    chk(irq, 1'b0, "R4 first tick loads 1");
    for (int e = 0; e < 3; e++) pulse_line();
    wr(16'hC001, 8'h00);
    pulse_line();
    chk(irq, 1'b0, "R4 realigned tick reloads");
    for (int e = 2; e <= 8; e++) pulse_line();
    chk(irq, 1'b0, "R4 pulse 8 after realign");
    pulse_line();
    chk(irq, 1'b1, "R4 pulse 9 after realign");

    // R4: pulse in the same cycle as a reload request is discarded
    arm(8'd0);
    vid_line_bit = 1'b1; @(posedge clk); #1;
    vid_line_bit = 1'b0;
    wr(16'hC001, 8'h00);
    chk(irq, 1'b0, "R4 simultaneous pulse dropped");
    pulse_line();
    chk(irq, 1'b1, "R4 next pulse ticks");

    // R5 R7: reload on zero uses a newly written value, then decrements
    arm(8'd2);
    for (int e = 1; e <= 17; e++) pulse_line();
    chk(irq, 1'b1, "R5 n=2 fires at 17");
    wr(16'hE000, 8'h00);
    wr(16'hE001, 8'h00);
    wr(16'hC000, 8'd3);
    chk(irq, 1'b0, "R7 write no effect on irq");
    for (int e = 18; e <= 48; e++) pulse_line();
    chk(irq, 1'b0, "R5 R7 pulse 48 count 1");
    pulse_line();
    chk(irq, 1'b1, "R5 R7 pulse 49 count 0");

    // R2: holding or rising the bit never counts
    arm(8'd0);
    vid_line_bit = 1'b1;
    for (int e = 0; e < 20; e++) begin @(posedge clk); #1; end
    chk(irq, 1'b0, "R2 no count on rise or hold");
    vid_line_bit = 1'b0; @(posedge clk); #1;
    chk(irq, 1'b1, "R2 fall counts");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule